// File: doc/BRIEF.md
# Bit-Serial CRC-16 Generator and Checker

This unit computes a 16-bit cyclic redundancy check one bit per clock. Message bits enter with the highest-degree coefficient first. A 16-stage linear feedback shift register divides X^16·A(X) by the chosen generator polynomial, using modulo-2 arithmetic throughout. Two generators are available, and the choice is made when a new message is started.

In generate mode, the unit appends the remainder to the message. Once the last message bit has been accepted, the 16 remainder bits leave on a serial output, most significant first, with an output-valid flag. The message followed by these bits forms a codeword that the generator divides exactly.

In check mode, the same register processes a received codeword: message bits, then CRC bits. One cycle after the last bit, a done pulse appears, and an error flag is raised with it when the final remainder is not zero.

Top module: `crc16_serial_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit clears its state. After that edge, `out_valid`, `out_bit`, `chk_done` and `chk_err` are all 0.
- R2: With `poly_sel`=0 the generator is X^16+X^15+X^2+1. In generate mode (`mode_check`=0), the edge after the bit carrying `msg_end` starts 16 consecutive cycles with `out_valid`=1. During these cycles `out_bit` carries the remainder of X^16·A(X) mod F(X), most significant bit first.
- R3: With `poly_sel`=1 the generator is X^16+X^12+X^5+1, and it is used exactly as described in R2.
- R4: `poly_sel` and `mode_check` are captured only in a cycle where `init` is high. Changing them while a message is in progress has no effect on the result.
- R5: In check mode, a codeword (message bits followed by their 16 CRC bits) raises `chk_done` for exactly one cycle, starting at the edge that accepts the bit carrying `msg_end`. In that cycle `chk_err` is 0.
- R6: In check mode, any codeword corrupted by an error burst of 16 bits or fewer gives `chk_err`=1 together with `chk_done`. `chk_err` is 0 whenever `chk_done` is 0.
- R7: `bit_in` is ignored in cycles where `bit_valid` is 0. Bits are also ignored after the end of a message, until the next `init`.
- R8: `out_valid` is never high for more than 16 consecutive cycles. It is never high in check mode. `chk_done` is never high in generate mode.
- R9: Asserting `init` during a message discards the partial remainder. The message that follows produces the same result as it would after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| init | input | 1 | Start a new message: clear the register, capture `poly_sel` and `mode_check` |
| poly_sel | input | 1 | 0: X^16+X^15+X^2+1, 1: X^16+X^12+X^5+1 |
| mode_check | input | 1 | 0: generate and append, 1: check a received codeword |
| bit_in | input | 1 | Serial data bit, highest degree first |
| bit_valid | input | 1 | `bit_in` is valid this cycle |
| msg_end | input | 1 | Marks the last valid bit of the message or codeword |
| out_bit | output | 1 | Serial remainder bit, most significant first |
| out_valid | output | 1 | `out_bit` is valid |
| chk_done | output | 1 | One-cycle pulse when a check completes |
| chk_err | output | 1 | Nonzero remainder; valid with `chk_done` |

## Verification
The register is observable only through the appended bits and the check flags. A single wrong stage or wrong tap therefore appears as a wrong bit within the 16 output cycles that follow the end of the message, or as a wrong `chk_err` on the done cycle. A stale register left over from an earlier message appears in the same places, so restart and gap scenarios compare their output against a fresh run. A sequencer that miscounts shows up at once as a 15-cycle or 17-cycle valid window, or as a done pulse in the wrong mode.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
    localparam int unsigned CRC_W = 16;
    // Low CRC_W bits of each generator; the X^CRC_W term is implicit.
    localparam logic [CRC_W-1:0] TAPS_GEN0 = 16'h8005;
    localparam logic [CRC_W-1:0] TAPS_GEN1 = 16'h1021;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_EMIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/crc16_tap_select.sv
module crc16_tap_select #(
    parameter int unsigned    W      = 16,
    parameter logic [W-1:0]   TAPS_0 = 16'h8005,
    parameter logic [W-1:0]   TAPS_1 = 16'h1021
) (
    input  logic         sel,
    output logic [W-1:0] taps
);
    always_comb begin
        taps = sel ? TAPS_1 : TAPS_0;
    end
endmodule

// File: rtl/crc16_lfsr_step.sv
module crc16_lfsr_step #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] taps,
    input  logic         din,
    input  logic         feed,    // 1: divide in a data bit, 0: plain shift
    output logic [W-1:0] nxt
);
    logic fb;

    always_comb begin
        fb = feed & (cur[W-1] ^ din);
    end

    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == 0) begin : g_lsb
            always_comb nxt[i] = fb & taps[i];
        end else begin : g_mid
            always_comb nxt[i] = cur[i-1] ^ (fb & taps[i]);
        end
    end
endmodule

// File: rtl/crc16_seq_ctrl.sv
module crc16_seq_ctrl
    import crc16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic mode_in,
    input  logic bit_valid,
    input  logic msg_end,
    output logic accept,
    output logic last_check,
    output logic emitting
);
    localparam int unsigned CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

    typedef struct packed {
        seq_state_e     st;
        logic           mode_chk;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d     = ctrl_q;
        accept     = 1'b0;
        last_check = 1'b0;
        emitting   = (ctrl_q.st == SEQ_EMIT);
        if (init) begin
            ctrl_d.st       = SEQ_RUN;
            ctrl_d.mode_chk = mode_in;
            ctrl_d.cnt      = '0;
        end else begin
            case (ctrl_q.st)
                SEQ_RUN: begin
                    accept = bit_valid;
                    if (bit_valid && msg_end) begin
                        last_check = ctrl_q.mode_chk;
                        ctrl_d.st  = ctrl_q.mode_chk ? SEQ_IDLE : SEQ_EMIT;
                        ctrl_d.cnt = '0;
                    end
                end
                SEQ_EMIT: begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    if (ctrl_q.cnt == CNT_LAST) begin
                        ctrl_d.st = SEQ_IDLE;
                    end
                end
                default: ctrl_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{st: SEQ_IDLE, mode_chk: 1'b0, cnt: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/crc16_serial_unit.sv
module crc16_serial_unit
    import crc16_pkg::*;
#(
    parameter int unsigned    W      = CRC_W,
    parameter logic [W-1:0]   TAPS_0 = TAPS_GEN0,
    parameter logic [W-1:0]   TAPS_1 = TAPS_GEN1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic poly_sel,
    input  logic mode_check,
    input  logic bit_in,
    input  logic bit_valid,
    input  logic msg_end,
    output logic out_bit,
    output logic out_valid,
    output logic chk_done,
    output logic chk_err
);
    typedef struct packed {
        logic [W-1:0] rem;
        logic         psel;
        logic         done;
        logic         err;
    } core_t;

    core_t core_d, core_q;

    logic         accept;
    logic         last_check;
    logic         emitting;
    logic [W-1:0] taps;
    logic [W-1:0] rem_step;

    crc16_seq_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .mode_in    (mode_check),
        .bit_valid  (bit_valid),
        .msg_end    (msg_end),
        .accept     (accept),
        .last_check (last_check),
        .emitting   (emitting)
    );

    crc16_tap_select #(.W(W), .TAPS_0(TAPS_0), .TAPS_1(TAPS_1)) u_taps (
        .sel  (core_q.psel),
        .taps (taps)
    );

    crc16_lfsr_step #(.W(W)) u_step (
        .cur  (core_q.rem),
        .taps (taps),
        .din  (bit_in),
        .feed (accept),
        .nxt  (rem_step)
    );

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        core_d.err  = 1'b0;
        if (init) begin
            core_d.rem  = '0;
            core_d.psel = poly_sel;
        end else if (accept) begin
            core_d.rem = rem_step;
            if (last_check) begin
                core_d.done = 1'b1;
                core_d.err  = |rem_step;
            end
        end else if (emitting) begin
            core_d.rem = rem_step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign out_valid = emitting;
    assign out_bit   = emitting & core_q.rem[W-1];
    assign chk_done  = core_q.done;
    assign chk_err   = core_q.err;
endmodule

// File: rtl/crc16_serial_unit_chk.sv
module crc16_serial_unit_chk #(
    parameter int unsigned W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic bit_valid,
    input logic msg_end,
    input logic out_valid,
    input logic out_bit,
    input logic chk_done,
    input logic chk_err
);
    localparam int unsigned RUN_W = $clog2(W + 2);
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (out_valid) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    // R1: reset clears all outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_bit && !chk_done && !chk_err));

    // R8: valid window never exceeds W cycles
    p_emit_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (run_q < RUN_W'(W)));

    // R8: generate output and check result never coincide
    p_mode_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && chk_done));

    // R5: done is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |=> !chk_done);

    // R5: done follows an accepted end-of-message bit
    p_done_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> $past(bit_valid && msg_end));

    // R6: error flag only accompanies done
    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_err |-> chk_done);
endmodule

bind crc16_serial_unit crc16_serial_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .msg_end   (msg_end),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .chk_done  (chk_done),
    .chk_err   (chk_err)
);

// File: tb/crc16_serial_unit_tb_top.sv
`timescale 1ns/1ps
module crc16_serial_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init = 1'b0, poly_sel = 1'b0, mode_check = 1'b0;
    logic bit_in = 1'b0, bit_valid = 1'b0, msg_end = 1'b0;
    logic out_bit, out_valid, chk_done, chk_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    crc16_serial_unit dut_i (
        .clk(clk), .rst_n(rst_n), .init(init), .poly_sel(poly_sel),
        .mode_check(mode_check), .bit_in(bit_in), .bit_valid(bit_valid),
        .msg_end(msg_end), .out_bit(out_bit), .out_valid(out_valid),
        .chk_done(chk_done), .chk_err(chk_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Long division of m*X^16 by the full 17-bit generator.
    function automatic logic [15:0] ref_crc(input logic p, input logic [63:0] m, input int len);
        logic [79:0] b;
        logic [16:0] g;
        g = p ? 17'h11021 : 17'h18005;
        b = {m, 16'h0000};
        for (int i = len + 15; i >= 16; i--) begin
            if (b[i]) b[i-:17] = b[i-:17] ^ g;
        end
        return b[15:0];
    endfunction

    task automatic do_init(input logic p, input logic m);
        @(negedge clk);
        init = 1'b1; poly_sel = p; mode_check = m;
        @(negedge clk);
        init = 1'b0;
    endtask

    task automatic drive_bit(input logic b, input logic last);
        @(negedge clk);
        bit_valid = 1'b1; bit_in = b; msg_end = last;
    endtask

    task automatic idle_cycle(input logic junk);
        @(negedge clk);
        bit_valid = 1'b0; msg_end = 1'b0; bit_in = junk;
    endtask

    task automatic send_bits(input logic [79:0] v, input int len, input bit ends, input bit gaps);
        for (int i = len - 1; i >= 0; i--) begin
            drive_bit(v[i], ends && (i == 0));
            if (gaps && i != 0) idle_cycle(~v[i]);
        end
        @(negedge clk);
        bit_valid = 1'b0; msg_end = 1'b0; bit_in = 1'b0;
    endtask

    // Called at the negedge right after the last bit was taken.
    task automatic collect(output logic [15:0] c, input string req);
        bit win_ok = 1'b1;
        bit no_done = 1'b1;
        c = '0;
        for (int k = 0; k < 16; k++) begin
            if (!out_valid) win_ok = 1'b0;
            if (chk_done) no_done = 1'b0;
            c = {c[14:0], out_bit};
            @(negedge clk);
        end
        check(win_ok, {req, " R8 valid for 16 cycles"}, 32'(win_ok), 32'd1);
        check(!out_valid, {req, " R8 valid drops after 16"}, 32'(out_valid), 32'd0);
        check(no_done, {req, " R8 no done in generate"}, 32'(no_done), 32'd1);
    endtask

    task automatic t_generate(input logic p, input logic [63:0] m, input int len, input bit gaps, input string req);
        logic [15:0] c;
        do_init(p, 1'b0);
        send_bits({16'h0, m}, len, 1'b1, gaps);
        collect(c, req);
        check(c == ref_crc(p, m, len), req, 32'(c), 32'(ref_crc(p, m, len)));
    endtask

    task automatic t_check(input logic p, input logic [63:0] m, input int len, input logic [79:0] flip, input bit exp_err, input string req);
        logic [79:0] cw;
        bit saw_valid = 1'b0;
        cw = (({16'h0, m} << 16) | {64'h0, ref_crc(p, m, len)}) ^ flip;
        do_init(p, 1'b1);
        send_bits(cw, len + 16, 1'b1, 1'b0);
        check(chk_done == 1'b1, {req, " done"}, 32'(chk_done), 32'd1);
        check(chk_err == exp_err, {req, " err"}, 32'(chk_err), 32'(exp_err));
        if (out_valid) saw_valid = 1'b1;
        @(negedge clk);
        check(chk_done == 1'b0 && chk_err == 1'b0, {req, " done one cycle"}, 32'(chk_done), 32'd0);
        check(!saw_valid && !out_valid, "R8 no output valid in check mode", 32'(saw_valid), 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!out_valid && !out_bit && !chk_done && !chk_err, "R1 outputs after reset",
              {28'h0, out_valid, out_bit, chk_done, chk_err}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_sel_hold();
        logic [15:0] c;
        do_init(1'b0, 1'b0);
        poly_sel = 1'b1; mode_check = 1'b1;
        send_bits({16'h0, 64'hC3A5}, 16, 1'b1, 1'b0);
        collect(c, "R4 select held");
        check(c == ref_crc(1'b0, 64'hC3A5, 16), "R4 select held", 32'(c), 32'(ref_crc(1'b0, 64'hC3A5, 16)));
    endtask

    task automatic t_restart();
        logic [15:0] c;
        do_init(1'b0, 1'b0);
        send_bits(80'h1F, 7, 1'b0, 1'b0);
        do_init(1'b1, 1'b0);
        send_bits({16'h0, 64'h9E37}, 16, 1'b1, 1'b0);
        collect(c, "R9 restart");
        check(c == ref_crc(1'b1, 64'h9E37, 16), "R9 restart", 32'(c), 32'(ref_crc(1'b1, 64'h9E37, 16)));
    endtask

    task automatic t_after_end();
        logic [15:0] c;
        do_init(1'b1, 1'b0);
        send_bits({16'h0, 64'h5A}, 8, 1'b1, 1'b0);
        collect(c, "R7 pre");
        send_bits(80'hFFFF, 16, 1'b1, 1'b0);
        check(!out_valid && !chk_done, "R7 bits after end ignored", {30'h0, out_valid, chk_done}, 32'h0);
    endtask

    initial begin
        #500000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_generate(1'b0, 64'h31, 8, 1'b0, "R2 gen0 byte");
        t_generate(1'b0, 64'hDEADBEEF_0123_4567, 64, 1'b0, "R2 gen0 long");
        t_generate(1'b0, 64'h1, 1, 1'b0, "R2 gen0 single bit");
        t_generate(1'b1, 64'h31, 8, 1'b0, "R3 gen1 byte");
        t_generate(1'b1, 64'hA5A5_F00F_1234, 48, 1'b0, "R3 gen1 long");
        t_generate(1'b1, 64'h0000_8001, 32, 1'b1, "R7 gaps ignored");
        t_sel_hold();
        t_restart();
        t_after_end();
        t_check(1'b0, 64'hCAFE_BABE, 32, 80'h0, 1'b0, "R5 clean gen0");
        t_check(1'b1, 64'h1357_9BDF, 32, 80'h0, 1'b0, "R5 clean gen1");
        t_check(1'b0, 64'hCAFE_BABE, 32, 80'h1 << 20, 1'b1, "R6 single flip gen0");
        t_check(1'b1, 64'h1357_9BDF, 32, 80'h8001 << 10, 1'b1, "R6 burst16 gen1");
        t_check(1'b0, 64'h0F0F_00FF, 32, 80'hFFFF << 30, 1'b1, "R6 burst16 gen0");
        t_check(1'b1, 64'hCAFE_BABE, 32, 80'h5 << 2, 1'b1, "R6 flip in crc field");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule